// File: doc/BRIEF.md
# DRAM Initialization Command Injector

This block lets software bring a DRAM device up by hand. It holds one 32-bit control word. A 3-bit mode field in that word picks a special mode. While a special mode is active, every host access that reaches the block is turned into one raw DRAM command and is not treated as a data transfer. Software steps through the power-up recipe by writing the mode field and then making one host access per command: no-operation, precharge of all banks, load of the mode register or the extended mode register, and auto refresh. For the two register-load commands, the host address supplies the value placed on the DRAM address and bank lines.

The block also controls the DRAM clock-enable lines across reset. Reset pulls every CKE line low. After reset is released, CKE stays low until software first writes a nonzero value to the mode field. All CKE lines then rise together and stay high until the next reset. When the mode field selects normal operation, the block refuses host accesses, and the normal scheduler outside this block serves them.

Host accesses use a valid/ready handshake. An access is taken on a clock edge where `host_valid` and `host_ready` are both high. The block then holds `host_ready` low until it has finished that access. The host must keep `host_valid` and `host_addr` stable until the access is taken. The block never stalls an access once it is taken, and a stall by the host costs nothing.

Top module: `dram_init_cmd_inj`

## Requirements
- R1: While `rst_n` is low, every `dram_cke` bit is 0 and `dram_cs_n` is 1. After reset, the control word reads back as 0x00000000.
- R2: After reset, `dram_cke` stays all zeros until a write to the control word carries a mode field (bits 6:4) other than 000. On the clock edge that takes that write, all `dram_cke` bits go high together. They stay high through any later write, including writes of mode 000, until the next reset.
- R3: Mode 001 issues a no-operation (`cs_n,ras_n,cas_n,we_n` = 0,1,1,1). Mode 010 issues precharge-all (0,0,1,0), with address bit 10 set, every other address bit 0 and bank 0. The reserved mode 101 behaves exactly like 001. Both of these commands drive address 0 and bank 0 except for bit 10 of precharge-all.
- R4: Modes 011 (mode register) and 100 (extended mode register) both issue a register-load command (0,0,0,0). The DRAM address is `host_addr[ADDR_LSB +: ROW_W]` and the bank is `host_addr[ADDR_LSB+ROW_W +: BANK_W]` of the access.
- R5: Mode 110 issues auto refresh (0,0,0,1) with address 0 and bank 0.
- R6: In modes 001 to 110, an access taken at edge E drives its command for exactly the one cycle after E. `host_ack` is high for exactly the following cycle. `host_ready` is low from E until `host_ack` falls, so the block takes at most one access every three cycles. Outside that command cycle, all four command pins are high.
- R7: In mode 000, an access is taken and no command is issued (`dram_cs_n` stays 1). `host_ack` is high for the one cycle after acceptance.
- R8: In mode 111, `host_ready` is low, no access is taken, no command is issued and `host_ack` stays low.
- R9: The control word's fields are: bit 31 for the enhanced address map, bits 6:4 for the mode, and bits 1:0 for the DRAM type (10 is the valid type, the others are reserved). All three fields read back exactly as written, including mode 101 and the reserved type codes. Every other bit reads 0 and ignores writes.
- R10: A write to any `cfg_addr` other than `REG_OFFSET` (0x124) leaves the control word and CKE unchanged. `cfg_rdata` is 0 whenever `cfg_addr` is not `REG_OFFSET`.
- R11: `map_enhanced` equals stored bit 31 and `dram_type` equals stored bits 1:0. Both outputs update on the edge that takes the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | CFG_AW (12) | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational from `cfg_addr`) |
| host_valid | input | 1 | Host access request |
| host_ready | output | 1 | Block can take an access |
| host_addr | input | HOST_AW (32) | Host access address |
| host_ack | output | 1 | One-cycle completion pulse |
| dram_cs_n | output | 1 | Chip select, active low |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_addr | output | ROW_W (14) | DRAM address lines |
| dram_ba | output | BANK_W (3) | DRAM bank lines |
| dram_cke | output | RANKS (4) | Clock enable per rank |
| map_enhanced | output | 1 | Enhanced address map selected |
| dram_type | output | 2 | Stored DRAM type field |

## Verification
Four corner cases get the most attention.

The first is CKE. A write of mode 000 with other fields set, or a write to a neighbouring offset, must not raise CKE, and a later return to 000 must not drop it. A design that decodes the whole word, or that tracks the current mode, would then toggle CKE at the wrong moment.

The second is the address mapping of the register-load commands. The bench uses host addresses whose bits differ on both sides of `ADDR_LSB` and of the bank boundary, so an off-by-one shift or a swapped bank slice gives the wrong address or bank.

The third is the codes with no command of their own. Reserved mode 101 must produce a no-operation, mode 000 must acknowledge without a chip select, and mode 111 must refuse the access. A decoder that falls through to a default command, or that accepts in normal mode, is caught.

The fourth is a reset in the middle of a run, which must clear the word and drop CKE.

// File: rtl/dinit_pkg.sv
package dinit_pkg;

  typedef enum logic [2:0] {
    MS_HOLD   = 3'b000,
    MS_NOP    = 3'b001,
    MS_PREALL = 3'b010,
    MS_LMR    = 3'b011,
    MS_LEMR   = 3'b100,
    MS_RSVD   = 3'b101,
    MS_REFR   = 3'b110,
    MS_NORMAL = 3'b111
  } mode_e;

  // cs_n, ras_n, cas_n, we_n
  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_pins_t;

  localparam cmd_pins_t PINS_DESEL  = '{1'b1, 1'b1, 1'b1, 1'b1};
  localparam cmd_pins_t PINS_NOP    = '{1'b0, 1'b1, 1'b1, 1'b1};
  localparam cmd_pins_t PINS_PREALL = '{1'b0, 1'b0, 1'b1, 1'b0};
  localparam cmd_pins_t PINS_LOADMR = '{1'b0, 1'b0, 1'b0, 1'b0};
  localparam cmd_pins_t PINS_REFR   = '{1'b0, 1'b0, 1'b0, 1'b1};

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_CMD  = 2'd1,
    SQ_ACK  = 2'd2
  } seq_state_e;

  // Field positions inside the control word
  localparam int MODE_LSB = 4;
  localparam int MODE_W   = 3;
  localparam int TYPE_LSB = 0;
  localparam int TYPE_W   = 2;
  localparam int ENH_BIT  = 31;

  function automatic logic mode_emits(input mode_e m);
    return (m != MS_HOLD) && (m != MS_NORMAL);
  endfunction

endpackage

// File: rtl/dinit_cfg_reg.sv
module dinit_cfg_reg
  import dinit_pkg::*;
#(
  parameter int          CFG_AW     = 12,
  parameter logic [11:0] REG_OFFSET = 12'h124
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CFG_AW-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output mode_e             mode,
  output logic              enh_map,
  output logic [TYPE_W-1:0] dtype,
  output logic              cke_wake
);

  localparam logic [CFG_AW-1:0] OFFS = CFG_AW'(REG_OFFSET);

  logic              hit;
  logic              wr_hit;
  logic [MODE_W-1:0] mode_q;
  logic              enh_q;
  logic [TYPE_W-1:0] type_q;
  logic [MODE_W-1:0] wmode;

  assign hit    = (addr == OFFS);
  assign wr_hit = wr_en && hit;
  assign wmode  = wdata[MODE_LSB +: MODE_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      enh_q  <= 1'b0;
      type_q <= '0;
    end else if (wr_hit) begin
      mode_q <= wmode;
      enh_q  <= wdata[ENH_BIT];
      type_q <= wdata[TYPE_LSB +: TYPE_W];
    end
  end

  // Wake request: first nonzero mode write; rank flops latch it
  assign cke_wake = wr_hit && (wmode != '0);

  always_comb begin
    rdata = '0;
    if (hit) begin
      rdata[ENH_BIT]             = enh_q;
      rdata[MODE_LSB +: MODE_W]  = mode_q;
      rdata[TYPE_LSB +: TYPE_W]  = type_q;
    end
  end

  assign mode    = mode_e'(mode_q);
  assign enh_map = enh_q;
  assign dtype   = type_q;

endmodule

// File: rtl/dinit_seq.sv
module dinit_seq
  import dinit_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  mode_e mode,
  input  logic  host_valid,
  output logic  host_ready,
  output logic  host_ack,
  output logic  load_cmd
);

  seq_state_e state_q, state_d;
  logic       take;

  assign host_ready = (state_q == SQ_IDLE) && (mode != MS_NORMAL);
  assign take       = host_valid && host_ready;
  assign load_cmd   = take && mode_emits(mode);
  assign host_ack   = (state_q == SQ_ACK);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SQ_IDLE: if (take) state_d = mode_emits(mode) ? SQ_CMD : SQ_ACK;
      SQ_CMD:  state_d = SQ_ACK;
      SQ_ACK:  state_d = SQ_IDLE;
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SQ_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/dinit_cmd_enc.sv
module dinit_cmd_enc
  import dinit_pkg::*;
#(
  parameter int HOST_AW  = 32,
  parameter int ROW_W    = 14,
  parameter int BANK_W   = 3,
  parameter int ADDR_LSB = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  mode_e              mode,
  input  logic [HOST_AW-1:0] host_addr,
  output cmd_pins_t          pins,
  output logic [ROW_W-1:0]   row,
  output logic [BANK_W-1:0]  bank
);

  localparam int BANK_LSB = ADDR_LSB + ROW_W;
  localparam int AP_BIT   = 10;
  localparam logic [ROW_W-1:0] AP_MASK = ROW_W'(1) << AP_BIT;

  cmd_pins_t         pins_d;
  logic [ROW_W-1:0]  row_d;
  logic [BANK_W-1:0] bank_d;

  always_comb begin
    pins_d = PINS_NOP;
    row_d  = '0;
    bank_d = '0;
    unique case (mode)
      MS_PREALL: begin
        pins_d = PINS_PREALL;
        row_d  = AP_MASK;
      end
      MS_LMR, MS_LEMR: begin
        pins_d = PINS_LOADMR;
        row_d  = host_addr[ADDR_LSB +: ROW_W];
        bank_d = host_addr[BANK_LSB +: BANK_W];
      end
      MS_REFR: pins_d = PINS_REFR;
      default: pins_d = PINS_NOP;
    endcase
  end

  // Output stage: one command cycle per load, deselect otherwise
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins <= PINS_DESEL;
      row  <= '0;
      bank <= '0;
    end else if (load) begin
      pins <= pins_d;
      row  <= row_d;
      bank <= bank_d;
    end else begin
      pins <= PINS_DESEL;
      row  <= '0;
      bank <= '0;
    end
  end

endmodule

// File: rtl/dram_init_cmd_inj.sv
module dram_init_cmd_inj
  import dinit_pkg::*;
#(
  parameter int          CFG_AW     = 12,
  parameter logic [11:0] REG_OFFSET = 12'h124,
  parameter int          HOST_AW    = 32,
  parameter int          ROW_W      = 14,
  parameter int          BANK_W     = 3,
  parameter int          ADDR_LSB   = 3,
  parameter int          RANKS      = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr_en,
  input  logic [CFG_AW-1:0]  cfg_addr,
  input  logic [31:0]        cfg_wdata,
  output logic [31:0]        cfg_rdata,
  input  logic               host_valid,
  output logic               host_ready,
  input  logic [HOST_AW-1:0] host_addr,
  output logic               host_ack,
  output logic               dram_cs_n,
  output logic               dram_ras_n,
  output logic               dram_cas_n,
  output logic               dram_we_n,
  output logic [ROW_W-1:0]   dram_addr,
  output logic [BANK_W-1:0]  dram_ba,
  output logic [RANKS-1:0]   dram_cke,
  output logic               map_enhanced,
  output logic [1:0]         dram_type
);

  mode_e     mode_cur;
  logic      cke_wake;
  logic      load_cmd;
  cmd_pins_t pins;

  dinit_cfg_reg #(.CFG_AW(CFG_AW), .REG_OFFSET(REG_OFFSET)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_wr_en),
    .addr     (cfg_addr),
    .wdata    (cfg_wdata),
    .rdata    (cfg_rdata),
    .mode     (mode_cur),
    .enh_map  (map_enhanced),
    .dtype    (dram_type),
    .cke_wake (cke_wake)
  );

  dinit_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode_cur),
    .host_valid (host_valid),
    .host_ready (host_ready),
    .host_ack   (host_ack),
    .load_cmd   (load_cmd)
  );

  dinit_cmd_enc #(
    .HOST_AW(HOST_AW), .ROW_W(ROW_W), .BANK_W(BANK_W), .ADDR_LSB(ADDR_LSB)
  ) u_enc (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_cmd),
    .mode      (mode_cur),
    .host_addr (host_addr),
    .pins      (pins),
    .row       (dram_addr),
    .bank      (dram_ba)
  );

  assign dram_cs_n  = pins.cs_n;
  assign dram_ras_n = pins.ras_n;
  assign dram_cas_n = pins.cas_n;
  assign dram_we_n  = pins.we_n;

  // One sticky clock-enable flop per rank, cleared only by reset
  for (genvar r = 0; r < RANKS; r++) begin : g_cke
    logic cke_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cke_q <= 1'b0;
      else if (cke_wake) cke_q <= 1'b1;
    end
    assign dram_cke[r] = cke_q;
  end

endmodule

// File: rtl/dinit_checker.sv
module dinit_checker
  import dinit_pkg::*;
#(
  parameter int          CFG_AW     = 12,
  parameter logic [11:0] REG_OFFSET = 12'h124,
  parameter int          RANKS      = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr_en,
  input logic [CFG_AW-1:0] cfg_addr,
  input logic [31:0]       cfg_wdata,
  input logic              host_valid,
  input logic              host_ready,
  input logic              host_ack,
  input logic              dram_cs_n,
  input logic [RANKS-1:0]  dram_cke,
  input mode_e             mode_cur
);

  // R1: reset holds every CKE low
  a_r1_cke_low_in_reset: assert property (@(posedge clk)
    !rst_n |-> (dram_cke == '0));

  // R2: CKE rises only after a nonzero mode write to the control word
  a_r2_cke_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_cke[0]) |-> $past(cfg_wr_en && (cfg_addr == CFG_AW'(REG_OFFSET))
                                 && (cfg_wdata[6:4] != 3'b000)));

  // R2: all ranks move together
  a_r2_cke_together: assert property (@(posedge clk) disable iff (!rst_n)
    (dram_cke == '0) || (dram_cke == '1));

  // R2: CKE never falls without reset
  a_r2_cke_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    dram_cke[0] |=> dram_cke[0]);

  // R6: command lasts one cycle and is followed by the acknowledge
  a_r6_cmd_then_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_cs_n |=> (dram_cs_n && host_ack));

  // R6: acknowledge is a single-cycle pulse
  a_r6_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |=> !host_ack);

  // R6: a taken access in a command mode drives the command next cycle
  a_r6_take_emits: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && host_ready && mode_emits(mode_cur)) |=> !dram_cs_n);

  // R7: mode 000 acknowledges without chip select
  a_r7_hold_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && host_ready && (mode_cur == MS_HOLD)) |=> (dram_cs_n && host_ack));

  // R8: a settled normal mode issues nothing
  a_r8_normal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_cur == MS_NORMAL) && $stable(mode_cur)) |-> dram_cs_n);

endmodule

bind dram_init_cmd_inj dinit_checker #(
  .CFG_AW(CFG_AW), .REG_OFFSET(REG_OFFSET), .RANKS(RANKS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_wr_en  (cfg_wr_en),
  .cfg_addr   (cfg_addr),
  .cfg_wdata  (cfg_wdata),
  .host_valid (host_valid),
  .host_ready (host_ready),
  .host_ack   (host_ack),
  .dram_cs_n  (dram_cs_n),
  .dram_cke   (dram_cke),
  .mode_cur   (mode_cur)
);

// File: tb/dram_init_cmd_inj_test.sv
module dram_init_cmd_inj_test;

  localparam int          CFG_AW   = 12;
  localparam logic [11:0] OFFS     = 12'h124;
  localparam int          HOST_AW  = 32;
  localparam int          ROW_W    = 14;
  localparam int          BANK_W   = 3;
  localparam int          ADDR_LSB = 3;
  localparam int          RANKS    = 4;
  localparam logic [31:0] RW_MASK  = 32'h8000_0073;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               cfg_wr_en;
  logic [CFG_AW-1:0]  cfg_addr;
  logic [31:0]        cfg_wdata;
  logic [31:0]        cfg_rdata;
  logic               host_valid;
  logic               host_ready;
  logic [HOST_AW-1:0] host_addr;
  logic               host_ack;
  logic               dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n;
  logic [ROW_W-1:0]   dram_addr;
  logic [BANK_W-1:0]  dram_ba;
  logic [RANKS-1:0]   dram_cke;
  logic               map_enhanced;
  logic [1:0]         dram_type;

  int checks = 0;
  int errors = 0;
  logic [31:0] model_word;
  logic        model_cke;

  always #2.5 clk = ~clk;

  dram_init_cmd_inj #(
    .CFG_AW(CFG_AW), .REG_OFFSET(OFFS), .HOST_AW(HOST_AW), .ROW_W(ROW_W),
    .BANK_W(BANK_W), .ADDR_LSB(ADDR_LSB), .RANKS(RANKS)
  ) uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .host_valid(host_valid),
    .host_ready(host_ready), .host_addr(host_addr), .host_ack(host_ack),
    .dram_cs_n(dram_cs_n), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n), .dram_addr(dram_addr), .dram_ba(dram_ba),
    .dram_cke(dram_cke), .map_enhanced(map_enhanced), .dram_type(dram_type)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_pins(input logic [2:0] m);
    case (m)
      3'b010:         return 4'b0010;
      3'b011, 3'b100: return 4'b0000;
      3'b110:         return 4'b0001;
      default:        return 4'b0111;
    endcase
  endfunction

  function automatic logic [ROW_W-1:0] exp_row(input logic [2:0] m,
                                               input logic [HOST_AW-1:0] a);
    if (m == 3'b010) return ROW_W'(1) << 10;
    if (m == 3'b011 || m == 3'b100) return a[ADDR_LSB +: ROW_W];
    return '0;
  endfunction

  function automatic logic [BANK_W-1:0] exp_bank(input logic [2:0] m,
                                                 input logic [HOST_AW-1:0] a);
    if (m == 3'b011 || m == 3'b100) return a[ADDR_LSB+ROW_W +: BANK_W];
    return '0;
  endfunction

  function automatic string req_of(input logic [2:0] m);
    case (m)
      3'b011, 3'b100: return "R4";
      3'b110:         return "R5";
      default:        return "R3";
    endcase
  endfunction

  task automatic cfg_write(input logic [CFG_AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0; cfg_addr = OFFS;
    if (a == OFFS) begin
      model_word = d & RW_MASK;
      if (d[6:4] != 3'b000) model_cke = 1'b1;
    end
    #1;
  endtask

  task automatic check_word(input string req);
    cfg_addr = OFFS; #1;
    chk(cfg_rdata == model_word, req, "readback", 64'(cfg_rdata), 64'(model_word));
    chk(map_enhanced == model_word[31] && dram_type == model_word[1:0], "R11",
        "enh/type pins", 64'({map_enhanced, dram_type}),
        64'({model_word[31], model_word[1:0]}));
  endtask

  task automatic check_cke(input string req);
    logic [RANKS-1:0] e;
    e = {RANKS{model_cke}};
    chk(dram_cke == e, req, "cke", 64'(dram_cke), 64'(e));
  endtask

  task automatic access(input logic [HOST_AW-1:0] a);
    logic [2:0] m;
    logic [3:0] act;
    m = model_word[6:4];
    @(negedge clk);
    host_valid = 1'b1; host_addr = a; #1;
    chk(host_ready == (m != 3'b111), (m == 3'b111) ? "R8" : "R6", "ready",
        64'(host_ready), 64'(m != 3'b111));
    if (m == 3'b111) begin
      for (int i = 0; i < 3; i++) begin
        @(negedge clk); #1;
        chk(dram_cs_n && !host_ack, "R8", "no command/ack",
            64'({dram_cs_n, host_ack}), 64'(2'b10));
      end
      host_valid = 1'b0;
      return;
    end
    @(negedge clk);
    host_valid = 1'b0; host_addr = $urandom; #1;
    if (m != 3'b000) begin
      act = {dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n};
      chk(act == exp_pins(m), req_of(m), "cmd pins", 64'(act), 64'(exp_pins(m)));
      chk(dram_addr == exp_row(m, a) && dram_ba == exp_bank(m, a), req_of(m),
          "addr/bank", 64'({dram_ba, dram_addr}), 64'({exp_bank(m, a), exp_row(m, a)}));
      chk(!host_ready && !host_ack, "R6", "cmd cycle ready/ack",
          64'({host_ready, host_ack}), 64'(0));
      @(negedge clk); #1;
    end
    chk(host_ack && dram_cs_n && !host_ready, (m == 3'b000) ? "R7" : "R6",
        "ack cycle", 64'({host_ack, dram_cs_n, host_ready}), 64'(3'b110));
    chk({dram_ras_n, dram_cas_n, dram_we_n} == 3'b111, "R6", "idle pins",
        64'({dram_ras_n, dram_cas_n, dram_we_n}), 64'(3'b111));
    @(negedge clk); #1;
    chk(!host_ack && host_ready, "R6", "after ack", 64'({host_ack, host_ready}),
        64'(2'b01));
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [2:0] md;
    process::self().srandom(32'h5eed_0124);
    rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_addr = OFFS; cfg_wdata = '0;
    host_valid = 1'b0; host_addr = '0;
    model_word = '0; model_cke = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(dram_cke == '0 && dram_cs_n, "R1", "reset outputs",
        64'({dram_cke, dram_cs_n}), 64'(1));
    chk(cfg_rdata == 32'h0, "R1", "reset word", 64'(cfg_rdata), 64'(0));
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1; check_cke("R2");

    // Mode 000 write with every other field set: CKE must stay low
    cfg_write(OFFS, 32'hFFFF_FF8F);
    check_cke("R2"); check_word("R9");
    access(32'h0000_1238);

    // Nonzero mode at a neighbouring offset: ignored
    cfg_write(OFFS + 12'h4, 32'h0000_0012);
    check_cke("R10"); check_word("R10");
    cfg_addr = OFFS + 12'h4; #1;
    chk(cfg_rdata == 32'h0, "R10", "other offset read", 64'(cfg_rdata), 64'(0));

    // First nonzero mode: CKE rises
    cfg_write(OFFS, 32'h0000_0012);
    check_cke("R2"); check_word("R9");
    access(32'hFFFF_FFF8);
    cfg_write(OFFS, 32'h0000_0002);
    check_cke("R2");

    // Directed sweep of every mode, including the reserved one
    for (int k = 1; k < 8; k++) begin
      cfg_write(OFFS, {1'b1, 24'h0, 1'b0, 3'(k), 2'b00, 2'(k)});
      check_word("R9");
      access(32'h0005_5558 ^ (32'(k) << 17));
    end
    cfg_write(OFFS, 32'h0000_0030);
    access({12'h0, 3'b101, 14'h2AAA, 3'b111});

    // Random mix
    for (int n = 0; n < 150; n++) begin
      md = 3'($urandom_range(0, 7));
      cfg_write(($urandom_range(0, 7) == 0) ? OFFS + 12'h8 : OFFS,
                ($urandom & ~32'h0000_0070) | (32'(md) << 4));
      check_word("R9"); check_cke("R2");
      access($urandom);
    end

    // Reset in the middle of a run
    @(negedge clk); rst_n = 1'b0; #1;
    model_word = '0; model_cke = 1'b0;
    check_cke("R1"); check_word("R1");
    @(negedge clk); rst_n = 1'b1;
    cfg_write(OFFS, 32'h0000_0060);
    check_cke("R2");
    access(32'h0);

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule